// File: doc/BRIEF.md
# Cascaded Two-Stage Watchdog Timer

This block is a watchdog made of two up-counters that run on a slow free-running clock. That clock is not related to the system clock. Software sets the block up through a small write/read register port in the system clock domain. Each stage counts ticks up to a programmable match value, and on a match it does nothing, raises a sticky interrupt or pulses a system reset request. Stage 1 can be chained behind stage 0 so that it advances only on stage-0 matches, which gives one long timeout equal to the product of the two periods.

Every write from the system side moves to the slow domain through a toggle handshake. The slow domain takes a snapshot of the whole configuration on the third slow edge after the write. A lock bit stops the enable bits from being cleared. A command word clears counters and interrupt flags. If an interrupt is left unserviced, it escalates to a reset on the third match in a row.

Top module: `wdt_cascade`

## Requirements
- R1: After `rst_ni` is released, `irq_o` and `rst_req_o` are low, and the control, match and status words all read back as zero.
- R2: When clear-on-match is set, an enabled stage with match value M matches once every M+1 of its ticks (M=0 gives a match on every tick).
- R3: When clear-on-match is clear, the counter keeps counting past the match value, so the next match comes only after the 16-bit count wraps.
- R4: When cascade (control bit 8) is set, stage 1 ticks only on stage-0 matches, so its reset interval is (M0+1)*(M1+1) slow cycles.
- R5: Mode fields are control bits 3:2 (stage 0) and 5:4 (stage 1). Code 0 means no action, 1 means interrupt and 2 means reset. Code 3 acts like code 0.
- R6: `rst_req_o` goes high for exactly one slow cycle per reset event, one slow cycle after the matching tick.
- R7: An interrupt flag stays set until software writes 1 to its clear bit in the command word (bit 2 for stage 0, bit 3 for stage 1). That write also zeroes the stage's unserviced-match tally.
- R8: In interrupt mode, the third match in a row with no interrupt clear in between raises `rst_req_o`.
- R9: While the lock (control bit 15) is set, a control write cannot clear the enable bits 1:0. A write that clears bit 15 releases the lock for later writes.
- R10: A write takes effect in the slow domain on the third slow edge after the write. An enabled stage therefore ticks first on the fourth edge.
- R11: Command bits 1:0 are a mask of counters to clear. When cascade is set, clearing either stage clears both.
- R12: Register map: address 0 is control (bits 15, 8:0, with bits 1:0 as the enables, 7:6 as clear-on-match and the rest as above), 1 is match 0, 2 is match 1, and 3 is the command on write and the interrupt status `{irq1, irq0}` on read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock for the register port |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| lf_clk_i | input | 1 | Slow counter clock, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for addr_i (combinational) |
| irq_o | output | 2 | Per-stage interrupt flags, synchronized to clk_i |
| rst_req_o | output | 1 | System reset request pulse in the lf_clk_i domain |

## Verification
The bench builds the block with its defaults: 16-bit counters, a two-flop synchronizer and an escalation limit of three. The clocks are a 10 ns system clock and a phase-shifted 70 ns slow clock. Small match values keep cascaded intervals such as 4x5 and 8x3 short enough to time exactly, and they let the three-match escalation play out in under twenty slow cycles. Writes are aligned to slow-clock negedges, so the third-edge latency can be checked on an exact edge. Periodic kicks and interrupt clears check that a timeout is held off only when the correct mask and cascade pairing are used.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_IRQ = 2'd1,
    MODE_RST = 2'd2,
    MODE_RSV = 2'd3
  } wdt_mode_e;

  // packed so that bits 8:0 line up with the control word
  typedef struct packed {
    logic       lock;
    logic       casc;
    logic [1:0] com;
    wdt_mode_e  mode1;
    wdt_mode_e  mode0;
    logic [1:0] en;
  } wdt_ctrl_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_MATCH0 = 2'd1;
  localparam logic [1:0] ADDR_MATCH1 = 2'd2;
  localparam logic [1:0] ADDR_CMD    = 2'd3;
  localparam int         LOCK_BIT    = 15;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [1:0]       irq_i,
  output wdt_ctrl_t        ctrl_o,
  output logic [CNT_W-1:0] match0_o,
  output logic [CNT_W-1:0] match1_o,
  output logic [3:0]       cmd_o,
  output logic             tgl_o,
  output logic [CNT_W-1:0] rdata_o
);
  wdt_ctrl_t ctrl_nxt;

  always_comb begin
    ctrl_nxt      = wdt_ctrl_t'({wdata_i[LOCK_BIT], wdata_i[8:0]});
    // lock holds enables set; the lock itself may be released
    if (ctrl_o.lock) ctrl_nxt.en = ctrl_nxt.en | ctrl_o.en;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= '0;
      match0_o <= '0;
      match1_o <= '0;
      cmd_o    <= '0;
      tgl_o    <= 1'b0;
    end else if (wr_en_i) begin
      tgl_o <= ~tgl_o;
      cmd_o <= (addr_i == ADDR_CMD) ? wdata_i[3:0] : 4'h0;
      case (addr_i)
        ADDR_CTRL:   ctrl_o   <= ctrl_nxt;
        ADDR_MATCH0: match0_o <= wdata_i;
        ADDR_MATCH1: match1_o <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL: begin
        rdata_o[8:0]      = ctrl_o[8:0];
        rdata_o[LOCK_BIT] = ctrl_o.lock;
      end
      ADDR_MATCH0: rdata_o = match0_o;
      ADDR_MATCH1: rdata_o = match1_o;
      default:     rdata_o[1:0] = irq_i;
    endcase
  end
endmodule

// File: rtl/wdt_xfer.sv
module wdt_xfer #(
  parameter int SYNC_FF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tgl_i,
  output logic apply_o
);
  logic [SYNC_FF:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_FF-1:0], tgl_i};
  end

  assign apply_o = sh_q[SYNC_FF] ^ sh_q[SYNC_FF-1];
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int ESC_LIMIT = 3,
  localparam int TW       = $clog2(ESC_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] match_i,
  input  logic             clr_on_match_i,
  input  wdt_mode_e        mode_i,
  input  logic             cnt_clr_i,
  input  logic             irq_clr_i,
  output logic             evt_o,
  output logic             rst_evt_o,
  output logic             irq_o,
  output logic [TW-1:0]    tally_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic          tick, at_match, flag_base, esc, irq_evt;
  logic [TW-1:0] tally_base;

  assign tick       = en_i & adv_i;
  assign at_match   = (cnt_o == match_i);
  // a clear landing on the match tick wins
  assign evt_o      = tick & at_match & ~cnt_clr_i;
  assign flag_base  = irq_o & ~irq_clr_i;
  assign tally_base = irq_clr_i ? '0 : tally_o;
  assign irq_evt    = evt_o && (mode_i == MODE_IRQ);
  assign esc        = irq_evt && (tally_base == TW'(ESC_LIMIT - 1));
  assign rst_evt_o  = (evt_o && (mode_i == MODE_RST)) || esc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o   <= '0;
      irq_o   <= 1'b0;
      tally_o <= '0;
    end else begin
      if (cnt_clr_i)                   cnt_o <= '0;
      else if (tick)                   cnt_o <= (at_match && clr_on_match_i) ? '0 : cnt_o + 1'b1;
      irq_o <= flag_base | irq_evt;
      if (irq_evt) tally_o <= esc ? '0 : tally_base + TW'(1);
      else         tally_o <= tally_base;
    end
  end
endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SYNC_FF   = 2,
  parameter int ESC_LIMIT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lf_clk_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [1:0]       irq_o,
  output logic             rst_req_o
);
  localparam int TW = $clog2(ESC_LIMIT + 1);

  wdt_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] match0_sys, match1_sys;
  logic [3:0]       cmd_sys;
  logic             tgl, apply;

  logic [1:0]            lf_en, lf_com, clr_req, cnt_clr, irq_clr;
  logic                  lf_casc_q;
  wdt_mode_e             lf_mode [2];
  logic [1:0][CNT_W-1:0] lf_match;
  logic [1:0][CNT_W-1:0] cnt;
  logic [1:0][TW-1:0]    tally;
  logic [1:0]            evt, rst_evt, irq_flag, adv;
  logic [SYNC_FF-1:0][1:0] irq_sh;

  wdt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .irq_i    (irq_o),
    .ctrl_o   (ctrl_q),
    .match0_o (match0_sys),
    .match1_o (match1_sys),
    .cmd_o    (cmd_sys),
    .tgl_o    (tgl),
    .rdata_o  (rdata_o)
  );

  wdt_xfer #(.SYNC_FF(SYNC_FF)) u_xfer (
    .clk_i   (lf_clk_i),
    .rst_ni  (rst_ni),
    .tgl_i   (tgl),
    .apply_o (apply)
  );

  // snapshot of the system-side config; stable for SYNC_FF slow cycles before apply
  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lf_en      <= '0;
      lf_com     <= '0;
      lf_casc_q  <= 1'b0;
      lf_mode[0] <= MODE_OFF;
      lf_mode[1] <= MODE_OFF;
      lf_match   <= '0;
    end else if (apply) begin
      lf_en       <= ctrl_q.en;
      lf_com      <= ctrl_q.com;
      lf_casc_q   <= ctrl_q.casc;
      lf_mode[0]  <= ctrl_q.mode0;
      lf_mode[1]  <= ctrl_q.mode1;
      lf_match[0] <= match0_sys;
      lf_match[1] <= match1_sys;
    end
  end

  assign clr_req    = apply ? cmd_sys[1:0] : 2'b00;
  assign irq_clr    = apply ? cmd_sys[3:2] : 2'b00;
  assign cnt_clr[0] = clr_req[0] | (lf_casc_q & clr_req[1]);
  assign cnt_clr[1] = clr_req[1] | (lf_casc_q & clr_req[0]);

  for (genvar s = 0; s < 2; s++) begin : g_stage
    if (s == 0) begin : g_root
      assign adv[s] = 1'b1;
    end else begin : g_chain
      assign adv[s] = ~lf_casc_q | evt[0];
    end

    wdt_stage #(.CNT_W(CNT_W), .ESC_LIMIT(ESC_LIMIT)) u_stage (
      .clk_i          (lf_clk_i),
      .rst_ni         (rst_ni),
      .en_i           (lf_en[s]),
      .adv_i          (adv[s]),
      .match_i        (lf_match[s]),
      .clr_on_match_i (lf_com[s]),
      .mode_i         (lf_mode[s]),
      .cnt_clr_i      (cnt_clr[s]),
      .irq_clr_i      (irq_clr[s]),
      .evt_o          (evt[s]),
      .rst_evt_o      (rst_evt[s]),
      .irq_o          (irq_flag[s]),
      .tally_o        (tally[s]),
      .cnt_o          (cnt[s])
    );
  end

  always_ff @(posedge lf_clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_req_o <= 1'b0;
    else         rst_req_o <= |rst_evt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_sh <= '0;
    else begin
      irq_sh[0] <= irq_flag;
      for (int i = 1; i < SYNC_FF; i++) irq_sh[i] <= irq_sh[i-1];
    end
  end

  assign irq_o = irq_sh[SYNC_FF-1];
endmodule

// File: rtl/wdt_cascade_chk.sv
module wdt_cascade_chk #(
  parameter int CNT_W     = 16,
  parameter int ESC_LIMIT = 3,
  localparam int TW       = $clog2(ESC_LIMIT + 1)
) (
  input logic                  clk_i,
  input logic                  lf_clk_i,
  input logic                  rst_ni,
  input logic                  lock_i,
  input logic [1:0]            en_i,
  input logic                  casc_i,
  input logic                  apply_i,
  input logic [1:0]            evt_i,
  input logic [1:0]            cnt_clr_i,
  input logic [1:0][CNT_W-1:0] cnt_i,
  input logic [1:0]            flag_i,
  input logic [1:0]            irq_clr_i,
  input logic [1:0][TW-1:0]    tally_i,
  input logic                  rst_req_i
);
  p_lock_en0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && en_i[0]) |=> en_i[0]);
  p_lock_en1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && en_i[1]) |=> en_i[1]);

  p_irq_sticky0_r7: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (flag_i[0] && !irq_clr_i[0]) |=> flag_i[0]);
  p_irq_sticky1_r7: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (flag_i[1] && !irq_clr_i[1]) |=> flag_i[1]);

  p_tally_bound_r8: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (tally_i[0] < TW'(ESC_LIMIT)) && (tally_i[1] < TW'(ESC_LIMIT)));

  p_casc_hold_r4: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    (casc_i && !apply_i && !evt_i[0]) |=> $stable(cnt_i[1]));

  p_clr_zero0_r11: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    cnt_clr_i[0] |=> (cnt_i[0] == '0));
  p_clr_zero1_r11: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    cnt_clr_i[1] |=> (cnt_i[1] == '0));

  p_rst_from_match_r6: assert property (@(posedge lf_clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(|evt_i));
endmodule

bind wdt_cascade wdt_cascade_chk #(.CNT_W(CNT_W), .ESC_LIMIT(ESC_LIMIT)) u_chk (
  .clk_i     (clk_i),
  .lf_clk_i  (lf_clk_i),
  .rst_ni    (rst_ni),
  .lock_i    (ctrl_q.lock),
  .en_i      (ctrl_q.en),
  .casc_i    (lf_casc_q),
  .apply_i   (apply),
  .evt_i     (evt),
  .cnt_clr_i (cnt_clr),
  .cnt_i     (cnt),
  .flag_i    (irq_flag),
  .irq_clr_i (irq_clr),
  .tally_i   (tally),
  .rst_req_i (rst_req_o)
);

// File: tb/wdt_cascade_bench.sv
module wdt_cascade_bench;
  localparam int SYS_PERIOD = 10;
  localparam int LF_PERIOD  = 70;
  localparam int NV         = 7;
  // {ctrl, match0, match1, expected reset interval in slow cycles}
  localparam logic [63:0] VEC [NV] = '{
    {16'h0049, 16'd5, 16'd0, 16'd6},
    {16'h0049, 16'd0, 16'd0, 16'd1},
    {16'h00A2, 16'd0, 16'd9, 16'd10},
    {16'h00E3, 16'd2, 16'd4, 16'd5},
    {16'h01E3, 16'd3, 16'd4, 16'd20},
    {16'h01E3, 16'd7, 16'd2, 16'd24},
    {16'h01E3, 16'd0, 16'd5, 16'd6}
  };

  logic        clk_i = 1'b0, lf_clk_i = 1'b0, rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  irq_o;
  logic        rst_req_o;

  int checks = 0, fails = 0, rst_total = 0;
  logic [15:0] rd_val;

  wdt_cascade u_wdt_cascade (
    .clk_i(clk_i), .rst_ni(rst_ni), .lf_clk_i(lf_clk_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .rst_req_o(rst_req_o)
  );

  always #(SYS_PERIOD/2) clk_i = ~clk_i;
  initial begin
    #3;
    forever #(LF_PERIOD/2) lf_clk_i = ~lf_clk_i;
  end

  always @(negedge lf_clk_i) if (rst_req_o === 1'b1) rst_total++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lfn(input int n);
    repeat (n) @(negedge lf_clk_i);
  endtask

  task automatic wr_lf(input logic [1:0] a, input logic [15:0] d);
    @(negedge lf_clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    wr_lf(a, d);
    lfn(4);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic do_reset();
    @(negedge lf_clk_i);
    rst_ni = 1'b0;
    lfn(2);
    rst_ni = 1'b1;
    lfn(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(SYS_PERIOD * 180000);
    fails++;
    $display("FAIL watchdog R1..: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int base, early;
    do_reset();

    // R1 reset state
    chk(irq_o == 2'b00 && rst_req_o == 1'b0, "R1 outputs", {irq_o, rst_req_o}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), rd_val);
      chk(rd_val == 16'h0, "R1 register", rd_val, 0);
    end

    // R12 readback and field masking
    cfg(2'd1, 16'h4FFF); rd(2'd1, rd_val); chk(rd_val == 16'h4FFF, "R12 match0", rd_val, 16'h4FFF);
    cfg(2'd2, 16'h0008); rd(2'd2, rd_val); chk(rd_val == 16'h0008, "R12 match1", rd_val, 16'h0008);
    cfg(2'd0, 16'h7E00); rd(2'd0, rd_val); chk(rd_val == 16'h0000, "R12 reserved", rd_val, 0);

    // R9 lock
    do_reset();
    cfg(2'd0, 16'h8003); rd(2'd0, rd_val); chk(rd_val == 16'h8003, "R9 lock set", rd_val, 16'h8003);
    cfg(2'd0, 16'h8000); rd(2'd0, rd_val); chk(rd_val == 16'h8003, "R9 locked disable", rd_val, 16'h8003);
    cfg(2'd0, 16'h0000); rd(2'd0, rd_val); chk(rd_val == 16'h0003, "R9 release", rd_val, 16'h0003);
    cfg(2'd0, 16'h0000); rd(2'd0, rd_val); chk(rd_val == 16'h0000, "R9 unlocked disable", rd_val, 0);

    // R2 R4 R6 interval table
    for (int v = 0; v < NV; v++) begin
      int n;
      do_reset();
      cfg(2'd1, VEC[v][47:32]);
      cfg(2'd2, VEC[v][31:16]);
      cfg(2'd0, VEC[v][63:48]);
      n = 0;
      while (!rst_req_o && n < 200) begin lfn(1); n++; end
      n = 0;
      do begin lfn(1); n++; end while (!rst_req_o && n < 200);
      chk(n == int'(VEC[v][15:0]), "R2/R4 interval R6", n, VEC[v][15:0]);
    end

    // R10 latency: write lands on 3rd slow edge, first tick on 4th
    do_reset();
    wr_lf(2'd0, 16'h0049);
    lfn(3); chk(rst_req_o == 1'b0, "R10 before apply", rst_req_o, 0);
    lfn(1); chk(rst_req_o == 1'b1, "R10 first tick", rst_req_o, 1);

    // R8 escalation: match0=4, events on edges 8,13,18
    do_reset();
    cfg(2'd1, 16'd4);
    wr_lf(2'd0, 16'h0045);
    early = 0;
    for (int i = 1; i <= 17; i++) begin lfn(1); if (rst_req_o) early++; end
    chk(early == 0, "R8 no early reset", early, 0);
    lfn(1); chk(rst_req_o == 1'b1, "R8 third match", rst_req_o, 1);
    chk(irq_o[0] == 1'b1, "R8 irq pending", irq_o, 1);
    lfn(1); chk(rst_req_o == 1'b0, "R6 single pulse", rst_req_o, 0);

    // R7 servicing the interrupt prevents escalation
    do_reset();
    cfg(2'd1, 16'd4);
    wr_lf(2'd0, 16'h0045);
    base = rst_total;
    for (int i = 0; i < 8; i++) begin lfn(6); wr_lf(2'd3, 16'h0004); end
    chk(rst_total == base, "R7 clear resets tally", rst_total - base, 0);
    cfg(2'd0, 16'h0000);
    cfg(2'd3, 16'h0004);
    lfn(1);
    chk(irq_o == 2'b00, "R7 irq clear", irq_o, 0);

    // R3 no clear-on-match: single match then long wrap
    do_reset();
    cfg(2'd1, 16'd2);
    cfg(2'd0, 16'h0005);
    base = rst_total;
    lfn(50);
    chk(rst_total == base, "R3 no repeat match", rst_total - base, 0);
    chk(irq_o[0] == 1'b1, "R3 irq sticky R7", irq_o, 1);

    // R5 mode 0 and mode 3 are inert
    do_reset();
    cfg(2'd1, 16'd1);
    cfg(2'd0, 16'h0041);
    base = rst_total;
    lfn(20);
    chk(rst_total == base && irq_o == 2'b00, "R5 mode off", {irq_o, 8'(rst_total - base)}, 0);
    cfg(2'd0, 16'h004D);
    lfn(20);
    chk(rst_total == base && irq_o == 2'b00, "R5 mode reserved", {irq_o, 8'(rst_total - base)}, 0);

    // R11 kick stage 0 before match
    do_reset();
    cfg(2'd1, 16'd9);
    wr_lf(2'd0, 16'h0049);
    base = rst_total;
    for (int i = 0; i < 10; i++) begin lfn(4); wr_lf(2'd3, 16'h0001); end
    chk(rst_total == base, "R11 kick holds off", rst_total - base, 0);
    lfn(15);
    chk(rst_total > base, "R11 timeout after kicks stop", rst_total - base, 1);

    // R11 cascade: mask bit0 alone clears both stages
    do_reset();
    cfg(2'd1, 16'd3);
    cfg(2'd2, 16'd2);
    wr_lf(2'd0, 16'h01E3);
    base = rst_total;
    for (int i = 0; i < 10; i++) begin lfn(3); wr_lf(2'd3, 16'h0001); end
    chk(rst_total == base, "R11 cascade joint clear", rst_total - base, 0);
    lfn(20);
    chk(rst_total > base, "R11 cascade timeout R4", rst_total - base, 1);

    finish_run();
  end
endmodule